// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy Engine

This block is a small DMA engine built around a register file of several channels and one copy datapath. Software programs a channel's start address, configuration word, X count, X modify, Y count and Y modify over a 32-bit register bus. Two channels form a fixed pair: a source channel and a destination channel. Writing the destination channel's configuration word with its enable bit set launches a byte copy. The copy reads from the source channel's start address and writes to the destination channel's start address.

The copy length comes from the destination channel's own fields. It is the X count times the magnitude of the signed X modify, scaled by Y count and Y modify in two-dimensional mode and halved for 16-bit word size. The engine then moves that length plus one bytes. The sign of X modify selects whether both addresses step up or step down. Each byte costs one read cycle and one write cycle on a single-port byte memory. A busy flag covers the whole copy, and a one-cycle done pulse follows the last write.

Top module: `mdma_copier`

## Requirements
- R1: The register address decodes the channel from bits [9:6] and the register index from bits [5:2], for 4 channels of 16 words each. An accepted write followed by a read of the same address returns the written value. A read of a channel number of 4 or more returns 0, and a write there stores nothing.
- R2: The access size code is 01 for 16 bits and 10 for 32 bits. A 16-bit write stores the low half of the write data with zero upper bits, and a 32-bit write stores all 32 bits. Read data appears one cycle after the read request.
- R3: A byte access (size code 00), a size code of 11, or an address with bits [1:0] not zero is rejected. Such an access raises the error flag in the following cycle, changes no register, and returns read data 0.
- R4: The copy starts only on an accepted write to index 2 (configuration) of channel 2 (destination) with data bit 0 set. A write with bit 0 clear, a write to another index, or a write to another channel's configuration only stores the value, and busy stays low.
- R5: The register indices are start address 1, X count 4, X modify 5, Y count 6 and Y modify 7. The source address is channel 3's start address. The byte count is (X count × |X modify|) + 1, where X modify is a signed 16-bit value.
- R6: When configuration bit 4 is set, the length before the final +1 is further multiplied by Y count and by Y modify.
- R7: When configuration bits [3:2] equal 01, the computed length is halved (shifted right by one) before the +1.
- R8: A positive X modify steps both addresses up by one per byte. A zero or negative X modify steps both addresses down by one per byte.
- R9: For each byte the engine reads the source address in one cycle and writes that byte to the destination address in the next. Busy is high for exactly 2 × byte count cycles, starting the cycle after the start write.
- R10: The done flag is high for exactly one cycle, in the cycle after the last byte write, and busy is low in that cycle.
- R11: A configuration write that arrives while busy is stored, but it does not restart or extend the running copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access request, one cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Register byte address |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after request |
| reg_err | output | 1 | Rejected access, one cycle after request |
| mem_addr | output | 16 | Byte memory address |
| mem_rd | output | 1 | Byte read strobe; data expected on mem_rdata next cycle |
| mem_wr | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The copy function is swept over X counts 1 to 3 and X modify values from −2 to 3. Each of these is tried in four shapes: plain, two-dimensional, halved, and two-dimensional plus halved. Comparing moved-byte counts and busy lengths across this grid tells apart the magnitude rule, the Y scaling and the halving. A zero and negative modify against a positive one separate the descending and ascending directions. A full memory compare after each run catches off-by-one lengths and bytes written outside the target range. Register sweeps over every channel and index, together with near-miss start writes (wrong index, wrong channel, enable clear, during busy), separate the true start condition from its neighbours.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mv_state_e;

    localparam int unsigned IDX_START = 1;
    localparam int unsigned IDX_CFG   = 2;
    localparam int unsigned IDX_XCNT  = 4;
    localparam int unsigned IDX_XMOD  = 5;
    localparam int unsigned IDX_YCNT  = 6;
    localparam int unsigned IDX_YMOD  = 7;

    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_FULL = 2'b10;
endpackage

// File: rtl/mdma_regfile.sv
module mdma_regfile #(
    parameter int NUM_CH = 4,
    parameter int SRC_CH = 3,
    parameter int DST_CH = 2,
    parameter int AW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [9:0]    reg_addr,
    input  logic [1:0]    reg_size,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          reg_err,
    output logic          cfg_wr,
    output logic [4:0]    cfg_wval,
    output logic [AW-1:0] src_start,
    output logic [AW-1:0] dst_start,
    output logic [15:0]   xcnt,
    output logic [15:0]   xmod,
    output logic [15:0]   ycnt,
    output logic [15:0]   ymod
);
    import mdma_pkg::*;

    localparam int NREG = 16;
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [31:0] rdata;
        logic        err;
    } rsp_t;

    logic [31:0] regs_q [NUM_CH][NREG];
    logic [31:0] regs_d [NUM_CH][NREG];
    rsp_t        rsp_d, rsp_q;

    logic [3:0]  ch;
    logic [3:0]  idx;
    logic        ok;
    logic        ch_ok;
    logic [31:0] store;

    assign ch    = reg_addr[9:6];
    assign idx   = reg_addr[5:2];
    assign ok    = (reg_size == SZ_HALF || reg_size == SZ_FULL) && (reg_addr[1:0] == 2'b00);
    assign ch_ok = (32'(ch) < 32'(NUM_CH));
    assign store = (reg_size == SZ_HALF) ? {16'h0000, reg_wdata[15:0]} : reg_wdata;

    always_comb begin
        regs_d = regs_q;
        rsp_d  = rsp_q;
        rsp_d.err = 1'b0;
        if (reg_sel) begin
            if (!ok) begin
                rsp_d.err   = 1'b1;
                rsp_d.rdata = '0;
            end else if (reg_wr) begin
                if (ch_ok) regs_d[ch[CH_W-1:0]][idx] = store;
            end else begin
                rsp_d.rdata = ch_ok ? regs_q[ch[CH_W-1:0]][idx] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++)
                for (int r = 0; r < NREG; r++)
                    regs_q[c][r] <= '0;
            rsp_q <= '0;
        end else begin
            regs_q <= regs_d;
            rsp_q  <= rsp_d;
        end
    end

    assign reg_rdata = rsp_q.rdata;
    assign reg_err   = rsp_q.err;
    assign cfg_wr    = reg_sel && reg_wr && ok && (32'(ch) == 32'(DST_CH)) && (32'(idx) == IDX_CFG);
    assign cfg_wval  = store[4:0];
    assign src_start = regs_q[SRC_CH][IDX_START][AW-1:0];
    assign dst_start = regs_q[DST_CH][IDX_START][AW-1:0];
    assign xcnt      = regs_q[DST_CH][IDX_XCNT][15:0];
    assign xmod      = regs_q[DST_CH][IDX_XMOD][15:0];
    assign ycnt      = regs_q[DST_CH][IDX_YCNT][15:0];
    assign ymod      = regs_q[DST_CH][IDX_YMOD][15:0];
endmodule

// File: rtl/mdma_len_calc.sv
module mdma_len_calc #(
    parameter int LEN_W = 32
) (
    input  logic [15:0]      xcnt,
    input  logic [15:0]      xmod,
    input  logic [15:0]      ycnt,
    input  logic [15:0]      ymod,
    input  logic             dim2d,
    input  logic [1:0]       wsize,
    output logic [LEN_W-1:0] len,
    output logic             dec
);
    logic [16:0]      mag;
    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] plane;
    logic [LEN_W-1:0] pick;

    always_comb begin
        mag   = xmod[15] ? (17'd0 - {1'b1, xmod}) : {1'b0, xmod};
        base  = LEN_W'(xcnt) * LEN_W'(mag);
        plane = base * LEN_W'(ycnt) * LEN_W'(ymod);
        pick  = dim2d ? plane : base;
        len   = (wsize == 2'b01) ? (pick >> 1) : pick;
        dec   = xmod[15] || (xmod == 16'd0);
    end
endmodule

// File: rtl/mdma_mover.sv
module mdma_mover #(
    parameter int AW    = 16,
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    src_i,
    input  logic [AW-1:0]    dst_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dec_i,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic             done
);
    import mdma_pkg::*;

    typedef struct packed {
        mv_state_e        st;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [LEN_W-1:0] rem;
        logic             dec;
        logic             done;
    } mv_t;

    mv_t mv_d, mv_q;

    always_comb begin
        mv_d      = mv_q;
        mv_d.done = 1'b0;
        unique case (mv_q.st)
            MV_IDLE: begin
                if (start) begin
                    mv_d.st  = MV_READ;
                    mv_d.src = src_i;
                    mv_d.dst = dst_i;
                    mv_d.rem = len_i;
                    mv_d.dec = dec_i;
                end
            end
            MV_READ: mv_d.st = MV_WRITE;
            MV_WRITE: begin
                if (mv_q.rem == '0) begin
                    mv_d.st   = MV_IDLE;
                    mv_d.done = 1'b1;
                end else begin
                    mv_d.st  = MV_READ;
                    mv_d.rem = mv_q.rem - 1'b1;
                    mv_d.src = mv_q.dec ? mv_q.src - 1'b1 : mv_q.src + 1'b1;
                    mv_d.dst = mv_q.dec ? mv_q.dst - 1'b1 : mv_q.dst + 1'b1;
                end
            end
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '{st: MV_IDLE, default: '0};
        else        mv_q <= mv_d;
    end

    assign mem_rd    = (mv_q.st == MV_READ);
    assign mem_wr    = (mv_q.st == MV_WRITE);
    assign mem_addr  = (mv_q.st == MV_READ) ? mv_q.src : mv_q.dst;
    assign mem_wdata = mem_rdata;
    assign busy      = (mv_q.st != MV_IDLE);
    assign done      = mv_q.done;
endmodule

// File: rtl/mdma_copier.sv
module mdma_copier #(
    parameter int NUM_CH = 4,
    parameter int SRC_CH = 3,
    parameter int DST_CH = 2,
    parameter int AW     = 16,
    parameter int LEN_W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [9:0]    reg_addr,
    input  logic [1:0]    reg_size,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          reg_err,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done
);
    logic             cfg_wr;
    logic [4:0]       cfg_wval;
    logic [AW-1:0]    src_start, dst_start;
    logic [15:0]      xcnt, xmod, ycnt, ymod;
    logic [LEN_W-1:0] len;
    logic             dec;
    logic             start;

    mdma_regfile #(.NUM_CH(NUM_CH), .SRC_CH(SRC_CH), .DST_CH(DST_CH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .cfg_wr(cfg_wr), .cfg_wval(cfg_wval),
        .src_start(src_start), .dst_start(dst_start),
        .xcnt(xcnt), .xmod(xmod), .ycnt(ycnt), .ymod(ymod)
    );

    mdma_len_calc #(.LEN_W(LEN_W)) u_len (
        .xcnt(xcnt), .xmod(xmod), .ycnt(ycnt), .ymod(ymod),
        .dim2d(cfg_wval[4]), .wsize(cfg_wval[3:2]), .len(len), .dec(dec)
    );

    assign start = cfg_wr && cfg_wval[0] && !busy;

    mdma_mover #(.AW(AW), .LEN_W(LEN_W)) u_mover (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_i(src_start), .dst_i(dst_start), .len_i(len), .dec_i(dec),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done)
    );
endmodule

// File: rtl/mdma_copier_chk.sv
module mdma_copier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic [1:0] reg_size,
    input logic       reg_err,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       busy,
    input logic       done
);
    p_one_port_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_read_then_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(mem_wr)));

    p_byte_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_size == 2'b00) |=> reg_err);

    p_start_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_sel && reg_wr));
endmodule

bind mdma_copier mdma_copier_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_size(reg_size), .reg_err(reg_err), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .busy(busy), .done(done)
);

// File: tb/mdma_copier_tb_top.sv
`timescale 1ns/1ps
module mdma_copier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [1:0]  reg_size = 2'b10;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int cycles = 0;

    logic [7:0] mem  [0:1023];
    logic [7:0] init [0:1023];
    logic [7:0] expm [0:1023];

    always #2.5 clk = ~clk;

    mdma_copier dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] ra(input int ch, input int idx);
        return 10'((ch << 6) | (idx << 2));
    endfunction

    task automatic bus_wr(input logic [9:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, input logic [1:0] sz,
                          output logic [31:0] d, output logic e);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_size = sz;
        @(negedge clk);
        reg_sel = 1'b0;
        d = reg_rdata; e = reg_err;
    endtask

    task automatic wait_done(output int bcyc);
        int t = 0;
        bcyc = 0;
        while (!done && t < 2000) begin
            if (busy) bcyc++;
            t++;
            @(negedge clk);
        end
    endtask

    task automatic run_copy(input int xc, input int xm, input int mode, input int seed);
        int s, yc, ym, src, dst, bcyc, w0;
        bit decr, ok;
        logic [31:0] cfg;
        string tag;
        yc = 2; ym = 2;
        cfg = 32'h1 | ((mode & 1) ? 32'h10 : 0) | ((mode & 2) ? 32'h4 : 0);
        s = xc * ((xm < 0) ? -xm : xm);
        if (mode & 1) s = s * yc * ym;
        if (mode & 2) s = s >> 1;
        decr = (xm <= 0);
        src = decr ? 400 : 100;
        dst = decr ? 900 : 600;
        tag = (mode == 0) ? "R5" : (mode == 1) ? "R6" : "R7";
        for (int i = 0; i < 1024; i++) begin
            init[i] = 8'(i * 13 + seed);
            mem[i] = init[i];
            expm[i] = init[i];
        end
        for (int k = 0; k <= s; k++)
            expm[decr ? dst - k : dst + k] = init[decr ? src - k : src + k];
        bus_wr(ra(3, 1), 2'b10, 32'(src));
        bus_wr(ra(2, 1), 2'b10, 32'(dst));
        bus_wr(ra(2, 4), 2'b10, 32'(xc));
        bus_wr(ra(2, 5), 2'b01, 32'(xm));
        bus_wr(ra(2, 6), 2'b10, 32'(yc));
        bus_wr(ra(2, 7), 2'b10, 32'(ym));
        w0 = wr_cnt;
        bus_wr(ra(2, 2), 2'b10, cfg);
        wait_done(bcyc);
        check({tag, " byte count"}, 32'(wr_cnt - w0), 32'(s + 1));
        check("R9 busy cycles", 32'(bcyc), 32'(2 * (s + 1)));
        check("R10 done high after copy", {31'b0, done}, 32'd1);
        check("R10 busy low with done", {31'b0, busy}, 32'd0);
        @(negedge clk);
        check("R10 done one cycle", {31'b0, done}, 32'd0);
        ok = 1'b1;
        for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) ok = 1'b0;
        check("R8 memory image after copy", {31'b0, ok}, 32'd1);
    endtask

    initial begin
        logic [31:0] d;
        logic e;
        int w0, bc;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R9 reset busy", {31'b0, busy}, 0);
        check("R10 reset done", {31'b0, done}, 0);
        check("R9 reset mem strobes", {30'b0, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        bus_rd(ra(2, 2), 2'b10, d, e);
        check("R1 reset register value", d, 0);

        // R1: every channel and index, even values so no start
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 16; r++)
                bus_wr(ra(c, r), 2'b10, 32'hA5000000 | 32'(c << 12) | 32'(r << 4));
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 16; r++) begin
                bus_rd(ra(c, r), 2'b10, d, e);
                check("R1 readback", d, 32'hA5000000 | 32'(c << 12) | 32'(r << 4));
            end
        check("R4 sweep caused no copy", 32'(wr_cnt), 0);
        bus_wr(ra(7, 3), 2'b10, 32'h12345678);
        bus_rd(ra(7, 3), 2'b10, d, e);
        check("R1 missing channel reads zero", d, 0);

        // R2 widths
        bus_wr(ra(1, 9), 2'b01, 32'hABCD1234);
        bus_rd(ra(1, 9), 2'b01, d, e);
        check("R2 half write zero-extends", d, 32'h00001234);
        bus_wr(ra(1, 9), 2'b10, 32'hDEADBEE0);
        bus_rd(ra(1, 9), 2'b10, d, e);
        check("R2 full write", d, 32'hDEADBEE0);

        // R3 rejects
        bus_rd(ra(1, 9), 2'b00, d, e);
        check("R3 byte read err", {31'b0, e}, 1);
        check("R3 byte read data", d, 0);
        bus_wr(ra(1, 9), 2'b00, 32'h11111110);
        bus_wr(ra(1, 9), 2'b11, 32'h22222220);
        bus_wr(ra(1, 9) | 10'd2, 2'b10, 32'h33333330);
        bus_rd(ra(1, 9), 2'b10, d, e);
        check("R3 rejected writes store nothing", d, 32'hDEADBEE0);
        check("R3 good read no err", {31'b0, e}, 0);
        bus_rd(ra(1, 9) | 10'd1, 2'b10, d, e);
        check("R3 misaligned err", {31'b0, e}, 1);

        // R4 near-miss starts
        w0 = wr_cnt;
        bus_wr(ra(2, 4), 2'b10, 32'd3);
        bus_wr(ra(2, 5), 2'b10, 32'd1);
        bus_wr(ra(2, 2), 2'b10, 32'h00000010);
        check("R4 enable clear no busy", {31'b0, busy}, 0);
        bus_rd(ra(2, 2), 2'b10, d, e);
        check("R4 enable clear stored", d, 32'h10);
        bus_wr(ra(3, 2), 2'b10, 32'h1);
        check("R4 source cfg no busy", {31'b0, busy}, 0);
        bus_wr(ra(2, 3), 2'b10, 32'h1);
        check("R4 other index no busy", {31'b0, busy}, 0);
        repeat (3) @(negedge clk);
        check("R4 no memory traffic", 32'(wr_cnt - w0), 0);

        // R5..R10 sweep
        for (int mode = 0; mode < 4; mode++)
            for (int xm = -2; xm <= 3; xm++)
                for (int xc = 1; xc <= 3; xc++)
                    run_copy(xc, xm, mode, mode * 31 + xm * 7 + xc);

        // R11: cfg write during busy
        bus_wr(ra(2, 4), 2'b10, 32'd5);
        bus_wr(ra(2, 5), 2'b10, 32'd2);
        w0 = wr_cnt;
        bus_wr(ra(2, 2), 2'b10, 32'h1);
        check("R11 running", {31'b0, busy}, 1);
        bus_wr(ra(2, 2), 2'b10, 32'h15);
        wait_done(bc);
        repeat (4) @(negedge clk);
        check("R11 no restart busy", {31'b0, busy}, 0);
        check("R11 byte count unchanged", 32'(wr_cnt - w0), 32'd11);
        bus_rd(ra(2, 2), 2'b10, d, e);
        check("R11 busy write stored", d, 32'h15);

        summary();
    end
endmodule